// File: doc/BRIEF.md
# Mini UART Register Interface

This block is the register front end of a reduced UART. A 32-bit bus that accesses whole words reaches a set of registers at fixed byte offsets. The serial side is abstracted away. A write to the data register sends the low byte out as a one-cycle transmit strobe, and the transmitter is always reported as drained. Received bytes arrive through a valid/ready handshake. They queue in a small circular FIFO, and a read of the data register pops them. The interrupt summary, the identify code, line status and extended status are all derived from the FIFO level and a two-bit interrupt enable.

The bus read path is combinational. `bus_rdata` reflects the addressed register during the cycle in which `bus_sel` is high with `bus_wr` low. Any state change that the access causes, such as a pop, an enable update, a flush or a transmit, takes effect at the rising edge that ends that cycle. The interrupt line is a combinational function of registered state, so it follows each change without extra latency.

Top module: `muart_regs`

## Requirements
- R1: After synchronous reset the FIFO is empty, both interrupt enables are clear, `irq` is low, `rx_ready` is high and `tx_valid` is low.
- R2: A write to offset 0x40 sets `tx_valid` high for exactly the following cycle, with `tx_data` equal to bits [7:0] of the written word. In every other cycle `tx_valid` is low.
- R3: A byte is accepted when `rx_valid` and `rx_ready` are both high. It is stored at slot (read pointer + level) modulo DEPTH, so reads return bytes in arrival order, across pointer wraparound as well.
- R4: `rx_ready` is low exactly while the FIFO holds DEPTH bytes. An offered byte is then dropped, and the level never exceeds DEPTH.
- R5: A read of offset 0x40 returns the byte at the read pointer. If the FIFO is not empty, the read also advances the pointer (modulo DEPTH) and lowers the level by one. A read of an empty FIFO returns that slot's old contents and changes nothing.
- R6: Offset 0x44 keeps written bits [1:0] (bit 0 enables the TX interrupt, bit 1 enables the RX interrupt) and reads back as 0xC0 OR those two bits.
- R7: `irq` is high when bit 0 of the enable is set, or when bit 1 of the enable is set and the FIFO is non-empty. Offset 0x00 reads as 1 when `irq` is high and as 0 otherwise.
- R8: Offset 0x48 reads as 0xC0, OR 0x4 when the FIFO is non-empty and 0x2 when it is empty, OR 0x1 when `irq` is low.
- R9: A write to offset 0x48 with bit 1 set empties the FIFO. A byte accepted in the same cycle becomes the only entry. A write to 0x48 with bit 1 clear leaves the FIFO unchanged.
- R10: Offset 0x54 reads as 0x60 OR (FIFO non-empty). Offset 0x64 reads as 0x30E OR (FIFO non-empty), with the FIFO level placed from bit 16 upward.
- R11: Offset 0x04 reads as 1 and offset 0x60 reads as 3. All other offsets read as 0, and writes to them have no effect on any register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | FIFO can take a byte |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_data | output | 8 | Transmitted byte |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the bus issues at most one access per cycle and holds `bus_addr` and `bus_wdata` stable while `bus_sel` is high. They also assume that `rx_valid` is only meaningful in the cycle it is sampled, and that a byte offered while `rx_ready` is low is simply lost. The stimulus drives every input on the falling edge and issues single-cycle accesses. A byte is offered together with a bus access in only one scenario, the same-cycle flush and push, and there the FIFO is known not to be full.

// File: rtl/muart_pkg.sv
package muart_pkg;

    localparam int REG_AW = 8;

    // register byte offsets
    localparam logic [REG_AW-1:0] OFF_IRQSUM = 8'h00;
    localparam logic [REG_AW-1:0] OFF_ENABLE = 8'h04;
    localparam logic [REG_AW-1:0] OFF_DATA   = 8'h40;
    localparam logic [REG_AW-1:0] OFF_IEN    = 8'h44;
    localparam logic [REG_AW-1:0] OFF_IID    = 8'h48;
    localparam logic [REG_AW-1:0] OFF_LSTAT  = 8'h54;
    localparam logic [REG_AW-1:0] OFF_CTRL   = 8'h60;
    localparam logic [REG_AW-1:0] OFF_XSTAT  = 8'h64;

    typedef struct packed {
        logic rx;
        logic tx;
    } irq_vec_t;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_TX,
        ACC_POP,
        ACC_IEN_WR,
        ACC_FLUSH
    } acc_e;

    function automatic acc_e decode_access(logic sel, logic wr,
                                           logic [REG_AW-1:0] a, logic flush_bit);
        if (!sel) return ACC_NONE;
        if (!wr)  return (a == OFF_DATA) ? ACC_POP : ACC_NONE;
        case (a)
            OFF_DATA: return ACC_TX;
            OFF_IEN:  return ACC_IEN_WR;
            OFF_IID:  return flush_bit ? ACC_FLUSH : ACC_NONE;
            default:  return ACC_NONE;
        endcase
    endfunction

endpackage

// File: rtl/muart_rxq.sv
module muart_rxq #(
    parameter int DEPTH = 8,
    parameter int PTR_W = 3,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [7:0]       push_data,
    input  logic             pop,
    input  logic             flush,
    output logic [7:0]       head,
    output logic [CNT_W-1:0] lvl
);
    localparam int SUM_W = CNT_W + 1;
    localparam logic [SUM_W-1:0] DEPTH_S = SUM_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_P  = PTR_W'(DEPTH - 1);

    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wslot;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] sum_wrap;

    always_comb begin
        sum      = SUM_W'(rd_ptr) + SUM_W'(lvl);
        sum_wrap = (sum >= DEPTH_S) ? (sum - DEPTH_S) : sum;
        wslot    = flush ? rd_ptr : sum_wrap[PTR_W-1:0];
    end

    assign head = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            lvl    <= '0;
        end else begin
            if (pop)
                rd_ptr <= (rd_ptr == LAST_P) ? '0 : rd_ptr + 1'b1;
            if (flush)
                lvl <= push ? CNT_W'(1) : '0;
            else if (push && !pop)
                lvl <= lvl + 1'b1;
            else if (pop && !push)
                lvl <= lvl - 1'b1;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= '0;
            else if (push && wslot == PTR_W'(i))
                mem[i] <= push_data;
        end
    end
endmodule

// File: rtl/muart_irq.sv
module muart_irq
    import muart_pkg::*;
(
    input  logic [1:0] ier,
    input  logic       nonempty,
    output irq_vec_t   pend,
    output logic       irq
);
    always_comb begin
        pend.tx = ier[0];
        pend.rx = ier[1] && nonempty;
        irq     = pend.tx || pend.rx;
    end
endmodule

// File: rtl/muart_rdmux.sv
module muart_rdmux
    import muart_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic [REG_AW-1:0] addr,
    input  logic              irq,
    input  logic [1:0]        ier,
    input  logic [CNT_W-1:0]  lvl,
    input  logic [7:0]        head,
    output logic [31:0]       rdata
);
    logic        nonempty;
    logic [31:0] ne_w;

    assign nonempty = (lvl != '0);
    assign ne_w     = {31'b0, nonempty};

    always_comb begin
        case (addr)
            OFF_IRQSUM: rdata = {31'b0, irq};
            OFF_ENABLE: rdata = 32'h1;
            OFF_DATA:   rdata = {24'b0, head};
            OFF_IEN:    rdata = 32'hC0 | {30'b0, ier};
            OFF_IID:    rdata = 32'hC0 | (nonempty ? 32'h4 : 32'h2) | {31'b0, !irq};
            OFF_LSTAT:  rdata = 32'h60 | ne_w;
            OFF_CTRL:   rdata = 32'h3;
            OFF_XSTAT:  rdata = 32'h30E | ne_w | (32'(lvl) << 16);
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/muart_regs.sv
module muart_regs
    import muart_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              irq
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    acc_e             acc;
    logic [CNT_W-1:0] fifo_lvl;
    logic [7:0]       fifo_head;
    logic [1:0]       ier_q;
    logic             nonempty, push, pop, flush;
    irq_vec_t         pend;

    assign acc      = decode_access(bus_sel, bus_wr, bus_addr, bus_wdata[1]);
    assign nonempty = (fifo_lvl != '0);
    assign rx_ready = (fifo_lvl < CNT_W'(DEPTH));
    assign push     = rx_valid && rx_ready;
    assign pop      = (acc == ACC_POP) && nonempty;
    assign flush    = (acc == ACC_FLUSH);

    always_ff @(posedge clk) begin
        if (rst) begin
            ier_q    <= '0;
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= (acc == ACC_TX);
            if (acc == ACC_TX)     tx_data <= bus_wdata[7:0];
            if (acc == ACC_IEN_WR) ier_q   <= bus_wdata[1:0];
        end
    end

    muart_rxq #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_rxq (
        .clk(clk), .rst(rst), .push(push), .push_data(rx_data),
        .pop(pop), .flush(flush), .head(fifo_head), .lvl(fifo_lvl)
    );

    muart_irq u_irq (
        .ier(ier_q), .nonempty(nonempty), .pend(pend), .irq(irq)
    );

    muart_rdmux #(.CNT_W(CNT_W)) u_rdmux (
        .addr(bus_addr), .irq(irq), .ier(ier_q), .lvl(fifo_lvl),
        .head(fifo_head), .rdata(bus_rdata)
    );
endmodule

// File: rtl/muart_regs_chk.sv
module muart_regs_chk
    import muart_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [REG_AW-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic [7:0]        tx_data,
    input logic              irq,
    input logic [CNT_W-1:0]  lvl,
    input logic [1:0]        ier
);
    logic wr_data, rd_data, wr_flush, acc_push;
    assign wr_data  = bus_sel && bus_wr && bus_addr == OFF_DATA;
    assign rd_data  = bus_sel && !bus_wr && bus_addr == OFF_DATA;
    assign wr_flush = bus_sel && bus_wr && bus_addr == OFF_IID && bus_wdata[1];
    assign acc_push = rx_valid && rx_ready;

    assert_tx_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        wr_data |=> tx_valid && tx_data == $past(bus_wdata[7:0]));

    assert_tx_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_data |=> !tx_valid);

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        lvl <= CNT_W'(DEPTH));

    assert_pop_step_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_data && lvl != '0 && !acc_push) |=> lvl == $past(lvl) - CNT_W'(1));

    assert_empty_read_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_data && lvl == '0 && !acc_push) |=> lvl == '0);

    assert_tx_irq_R7: assert property (@(posedge clk) disable iff (rst)
        ier[0] |-> irq);

    assert_flush_empty_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_flush && !acc_push) |=> lvl == '0);
endmodule

bind muart_regs muart_regs_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .irq(irq), .lvl(fifo_lvl), .ier(ier_q)
);

// File: tb/muart_regs_tb.sv
module muart_regs_tb;
    localparam int D = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, tx_valid, irq;
    logic [7:0]  tx_data;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] m_mem [D];
    int m_rd  = 0;
    int m_cnt = 0;

    always #5 clk = ~clk;

    muart_regs #(.DEPTH(D)) u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    function automatic logic [31:0] xstat_exp();
        return 32'h30E | ((m_cnt != 0) ? 32'h1 : 32'h0) | (32'(m_cnt) << 16);
    endfunction

    task automatic push(logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0;
        if (m_cnt < D) begin
            m_mem[(m_rd + m_cnt) % D] = b;
            m_cnt++;
        end
    endtask

    task automatic pop_check(string req);
        logic [31:0] d;
        logic [7:0]  e;
        e = m_mem[m_rd];
        rd(8'h40, d);
        check(req, d, {24'b0, e});
        if (m_cnt > 0) begin
            m_cnt--;
            m_rd = (m_rd + 1) % D;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 rx_ready", {31'b0, rx_ready}, 32'h1);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 tx_valid", {31'b0, tx_valid}, 32'h0);
        rd(8'h44, d); check("R1/R6 ien", d, 32'hC0);
        rd(8'h48, d); check("R8 iid idle", d, 32'hC3);
        rd(8'h54, d); check("R10 lstat empty", d, 32'h60);
        rd(8'h64, d); check("R10 xstat empty", d, 32'h30E);
        rd(8'h00, d); check("R7 summary idle", d, 32'h0);
    endtask

    task automatic t_const();
        logic [31:0] d;
        rd(8'h04, d); check("R11 enables", d, 32'h1);
        rd(8'h60, d); check("R11 control", d, 32'h3);
        wr(8'h4C, 32'hFFFF_FFFF);
        wr(8'h5C, 32'hFFFF_FFFF);
        wr(8'h80, 32'hFFFF_FFFF);
        check("R11 ignored write tx", {31'b0, tx_valid}, 32'h0);
        check("R11 ignored write irq", {31'b0, irq}, 32'h0);
        rd(8'h44, d); check("R11 ien untouched", d, 32'hC0);
        rd(8'h5C, d); check("R11 scratch zero", d, 32'h0);
        rd(8'h4C, d); check("R11 lcr zero", d, 32'h0);
        rd(8'h80, d); check("R11 unknown zero", d, 32'h0);
    endtask

    task automatic t_tx();
        wr(8'h40, 32'h0000_01A5);
        check("R2 strobe", {31'b0, tx_valid}, 32'h1);
        check("R2 byte", {24'b0, tx_data}, 32'hA5);
        @(negedge clk);
        check("R2 one cycle", {31'b0, tx_valid}, 32'h0);
        wr(8'h40, 32'h3C);
        check("R2 second byte", {24'b0, tx_data}, 32'h3C);
    endtask

    task automatic t_order();
        logic [31:0] d;
        push(8'h11); push(8'h22); push(8'h33);
        rd(8'h64, d); check("R10 xstat level 3", d, xstat_exp());
        rd(8'h54, d); check("R10 lstat data", d, 32'h61);
        pop_check("R3 order 1"); pop_check("R3 order 2"); pop_check("R3 order 3");
        pop_check("R5 empty read stale");
        rd(8'h64, d); check("R5 empty read no change", d, 32'h30E);
    endtask

    task automatic t_full();
        logic [31:0] d;
        for (int i = 0; i < D; i++) push(8'h80 + 8'(i));
        check("R4 ready low when full", {31'b0, rx_ready}, 32'h0);
        push(8'hEE);
        rd(8'h64, d); check("R4 level held at depth", d, xstat_exp());
        for (int i = 0; i < D; i++) pop_check("R3/R4 wrap order");
        check("R4 ready back", {31'b0, rx_ready}, 32'h1);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        wr(8'h44, 32'hFF);
        rd(8'h44, d); check("R6 ien masked", d, 32'hC3);
        check("R7 tx irq", {31'b0, irq}, 32'h1);
        rd(8'h48, d); check("R8 iid tx pending", d, 32'hC2);
        wr(8'h44, 32'h2);
        check("R7 rx irq empty", {31'b0, irq}, 32'h0);
        push(8'h5A);
        check("R7 rx irq data", {31'b0, irq}, 32'h1);
        rd(8'h00, d); check("R7 summary", d, 32'h1);
        rd(8'h48, d); check("R8 iid rx", d, 32'hC4);
        pop_check("R5 pop");
        check("R7 rx irq cleared", {31'b0, irq}, 32'h0);
        rd(8'h48, d); check("R8 iid cleared", d, 32'hC3);
        wr(8'h44, 32'h0);
    endtask

    task automatic t_flush();
        logic [31:0] d;
        push(8'h01); push(8'h02); push(8'h03);
        wr(8'h48, 32'h4);
        rd(8'h64, d); check("R9 no flush bit1 clear", d, xstat_exp());
        wr(8'h48, 32'h2);
        m_cnt = 0;
        rd(8'h54, d); check("R9 flushed lstat", d, 32'h60);
        rd(8'h64, d); check("R9 flushed xstat", d, 32'h30E);
        push(8'h44); push(8'h55);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h48; bus_wdata = 32'h2;
        rx_valid = 1'b1; rx_data = 8'h77;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; rx_valid = 1'b0;
        m_cnt = 0;
        m_mem[m_rd] = 8'h77;
        m_cnt = 1;
        rd(8'h64, d); check("R9 flush with push level", d, xstat_exp());
        pop_check("R9 flush with push byte");
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        report();
    end

    initial begin
        for (int i = 0; i < D; i++) m_mem[i] = 8'h00;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_const();
        t_tx();
        t_order();
        t_full();
        t_irq();
        t_flush();
        repeat (2) @(negedge clk);
        report();
    end
endmodule